// File: doc/BRIEF.md
# Linked-Ring Transmit Descriptor Walker

This block walks a ring of transmit descriptors held in shared memory and passes each ready frame to a transmit datapath. Software programs a 32-bit ring base address as two 16-bit halves, then writes a poll command. The walker fetches the descriptor at its current position one 32-bit word at a time through a request/valid read port. It checks the ownership flag in the status half-word. If the controller owns the descriptor, the walker offers the buffer pointer and length on a frame handshake. It then writes the status back with ownership released, pulses a completion event and moves to the address held in the descriptor's link word.

The ring is closed only by its links: the last descriptor points back to the first, and no index arithmetic is involved. A scan stops at the first descriptor not owned by the controller. It then waits for the next poll command. A synchronous ring reset abandons any walk in flight and returns the position to the programmed base. A descriptor whose length lies outside the legal frame range is not sent. Its ownership is still released, and a separate error pulse flags it.

Top module: `tx_desc_walker`

## Requirements
- R1: While reset is active and right after it, the read request, write request, frame valid, completion pulse and error pulse are all low, and the current position is address 0.
- R2: A write with select 0 loads bits 15:0 of the ring base and a write with select 1 loads bits 31:16. Either write, while the walker is idle, also moves the current position to the updated base.
- R3: A write of value 1 with select 2 starts a scan at the current position. A write of any other value with select 2 starts nothing.
- R4: A descriptor is read as three words at position +0, +4 and +8. Word 0 holds the status in bits 15:0 and the length in bits 27:16; bits 31:28 are ignored. Word 1 holds the buffer address and word 2 the link address.
- R5: If status bit 15 of the fetched word 0 is clear, the walker reads no further words, sends nothing, writes nothing, keeps its position and idles until the next poll command.
- R6: For an owned descriptor with a length from 60 to 1514, frame valid rises with the buffer address and length and holds them stable until frame done.
- R7: After frame done, the walker writes the status with bit 15 cleared and all other bits unchanged to the descriptor's +0 address. On the write acknowledge it pulses the completion output for one cycle and continues the scan at the link address.
- R8: For an owned descriptor with a length below 60 or above 1514, the walker sends no frame, writes back the status with bit 15 cleared, pulses the error output instead of the completion output, and follows the link.
- R9: The walk follows link addresses only, so a ring whose last link points at the first descriptor wraps around.
- R10: The read request stays asserted with a stable address until a valid cycle arrives, whatever the latency. A valid cycle without a request has no effect.
- R11: A ring reset drops every request and frame valid in the following cycle, moves the position back to the base, clears a pending poll, and suppresses the write-back of the abandoned descriptor.
- R12: A poll command received during a scan is remembered, and one further scan starts from the stop position once the walk ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ringRst | input | 1 | Synchronous ring reset: abandon walk, rewind to base |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 base low, 1 base high, 2 poll |
| regWrData | input | 16 | Register write data |
| memRdReq | output | 1 | Descriptor word read request |
| memRdAddr | output | 32 | Byte address of requested word |
| memRdValid | input | 1 | Read data valid |
| memRdData | input | 32 | Read data word |
| memWrReq | output | 1 | Status write-back request |
| memWrAddr | output | 32 | Byte address of status half-word |
| memWrData | output | 16 | Status value written back |
| memWrAck | input | 1 | Write-back accepted |
| frameValid | output | 1 | Frame offered to the transmit datapath |
| frameAddr | output | 32 | Frame buffer address |
| frameLen | output | 12 | Frame length in bytes |
| frameDone | input | 1 | Transmit datapath finished the frame |
| txDone | output | 1 | One-cycle completion pulse per sent frame |
| txLenErr | output | 1 | One-cycle pulse per descriptor skipped for bad length |

## Verification
The first pattern is a three-entry ring with every entry owned and a read latency of one cycle. It shows that the walker sends each frame in link order, wraps, releases ownership and stops on the first entry it has already released. A second pass uses lengths of 59, 1515 and 60 with a three-cycle latency. This separates the length window's edges from the send path and shows that slow reads do not change the result. Further patterns cover a poll command arriving mid-scan, a ring reset during a frame offer, base rewrites while idle and a stray valid with no request. Each of these separates the remembered-poll, rewind and ignore behaviours from the plain walk.

// File: rtl/txr_pkg.sv
package txr_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_STAT,
    S_RD_BUF,
    S_RD_NEXT,
    S_CHECK,
    S_SEND,
    S_WB
  } walk_state_t;

  // strobes from the walk controller to the descriptor datapath
  typedef struct packed {
    logic [1:0] rdIdx;
    logic       capStat;
    logic       capBuf;
    logic       capNext;
    logic       advance;
    logic       rewind;
    logic       clrPoll;
    logic       finishOk;
    logic       finishErr;
  } walk_strobe_t;

endpackage

// File: rtl/txr_datapath.sv
module txr_datapath
  import txr_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int REG_W   = 16,
  parameter int STAT_W  = 16,
  parameter int LEN_W   = 12,
  parameter int OWN_BIT = 15,
  parameter int LEN_MIN = 60,
  parameter int LEN_MAX = 1514
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              idle,
  input  walk_strobe_t      stb,
  input  logic [ADDR_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [STAT_W-1:0] memWrData,
  output logic [ADDR_W-1:0] frameAddr,
  output logic [LEN_W-1:0]  frameLen,
  output logic              pollPending,
  output logic              ownerIn,
  output logic              lenOk,
  output logic              txDone,
  output logic              txLenErr
);
  localparam int HI_W = ADDR_W - REG_W;
  localparam logic [1:0] SEL_BASE_LO = 2'd0;
  localparam logic [1:0] SEL_BASE_HI = 2'd1;
  localparam logic [1:0] SEL_POLL    = 2'd2;
  localparam logic [REG_W-1:0] POLL_GO = REG_W'(1);
  localparam logic [STAT_W-1:0] OWN_MASK = STAT_W'(1) << OWN_BIT;

  logic [ADDR_W-1:0] baseReg, baseNext, curPtr, bufReg, nextReg;
  logic [STAT_W-1:0] statReg;
  logic [LEN_W-1:0]  lenReg;
  logic              baseWr, pollWr;

  always_comb begin
    baseNext = baseReg;
    baseWr   = 1'b0;
    if (regWrEn && regSel == SEL_BASE_LO) begin
      baseNext[REG_W-1:0] = regWrData;
      baseWr = 1'b1;
    end else if (regWrEn && regSel == SEL_BASE_HI) begin
      baseNext[ADDR_W-1:REG_W] = regWrData[HI_W-1:0];
      baseWr = 1'b1;
    end
  end

  assign pollWr = regWrEn && (regSel == SEL_POLL) && (regWrData == POLL_GO);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) baseReg <= '0;
    else if (baseWr) baseReg <= baseNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                curPtr <= '0;
    else if (stb.rewind)      curPtr <= baseReg;
    else if (stb.advance)     curPtr <= nextReg;
    else if (baseWr && idle)  curPtr <= baseNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pollPending <= 1'b0;
    else if (stb.rewind)  pollPending <= 1'b0;
    else if (pollWr)      pollPending <= 1'b1;
    else if (stb.clrPoll) pollPending <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statReg <= '0;
      lenReg  <= '0;
      bufReg  <= '0;
      nextReg <= '0;
    end else begin
      if (stb.capStat) begin
        statReg <= memRdData[STAT_W-1:0];
        lenReg  <= memRdData[STAT_W +: LEN_W];
      end
      if (stb.capBuf)  bufReg  <= memRdData;
      if (stb.capNext) nextReg <= memRdData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txDone   <= 1'b0;
      txLenErr <= 1'b0;
    end else begin
      txDone   <= stb.finishOk;
      txLenErr <= stb.finishErr;
    end
  end

  assign memRdAddr = curPtr + ADDR_W'({stb.rdIdx, 2'b00});
  assign memWrAddr = curPtr;
  assign memWrData = statReg & ~OWN_MASK;
  assign frameAddr = bufReg;
  assign frameLen  = lenReg;
  assign ownerIn   = memRdData[OWN_BIT];
  assign lenOk     = (lenReg >= LEN_W'(LEN_MIN)) && (lenReg <= LEN_W'(LEN_MAX));

  // R8: the two finish pulses never coincide
  p_finish_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(txDone && txLenErr));

  // R11: a rewind leaves no poll pending
  p_rewind_clears_poll_r11: assert property (@(posedge clk) disable iff (!rstN)
    stb.rewind |=> !pollPending);

endmodule

// File: rtl/txr_ctrl.sv
module txr_ctrl
  import txr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         ringRst,
  input  logic         pollPending,
  input  logic         memRdValid,
  input  logic         ownerIn,
  input  logic         lenOk,
  input  logic         frameDone,
  input  logic         memWrAck,
  output logic         memRdReq,
  output logic         memWrReq,
  output logic         frameValid,
  output logic         idle,
  output walk_strobe_t stb
);
  walk_state_t st, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    nxt        = st;
    stb        = '0;
    memRdReq   = 1'b0;
    memWrReq   = 1'b0;
    frameValid = 1'b0;
    case (st)
      S_IDLE: begin
        if (pollPending) begin
          stb.clrPoll = 1'b1;
          nxt = S_RD_STAT;
        end
      end
      S_RD_STAT: begin
        memRdReq  = 1'b1;
        stb.rdIdx = 2'd0;
        if (memRdValid) begin
          if (ownerIn) begin
            stb.capStat = 1'b1;
            nxt = S_RD_BUF;
          end else begin
            nxt = S_IDLE;
          end
        end
      end
      S_RD_BUF: begin
        memRdReq  = 1'b1;
        stb.rdIdx = 2'd1;
        if (memRdValid) begin
          stb.capBuf = 1'b1;
          nxt = S_RD_NEXT;
        end
      end
      S_RD_NEXT: begin
        memRdReq  = 1'b1;
        stb.rdIdx = 2'd2;
        if (memRdValid) begin
          stb.capNext = 1'b1;
          nxt = S_CHECK;
        end
      end
      S_CHECK: begin
        nxt = lenOk ? S_SEND : S_WB;
      end
      S_SEND: begin
        frameValid = 1'b1;
        if (frameDone) nxt = S_WB;
      end
      S_WB: begin
        memWrReq = 1'b1;
        if (memWrAck) begin
          stb.advance   = 1'b1;
          stb.finishOk  = lenOk;
          stb.finishErr = !lenOk;
          nxt = S_RD_STAT;
        end
      end
      default: nxt = S_IDLE;
    endcase
    if (ringRst) begin
      stb.capStat   = 1'b0;
      stb.capBuf    = 1'b0;
      stb.capNext   = 1'b0;
      stb.advance   = 1'b0;
      stb.clrPoll   = 1'b0;
      stb.finishOk  = 1'b0;
      stb.finishErr = 1'b0;
      stb.rewind    = 1'b1;
      nxt = S_IDLE;
    end
  end

  assign idle = (st == S_IDLE);

  // R11: ring reset silences every request on the next cycle
  p_rst_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    ringRst |=> !memRdReq && !memWrReq && !frameValid);

  // R5: an unowned status word ends the scan
  p_unowned_stop_r5: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq && memRdValid && stb.rdIdx == 2'd0 && !ownerIn && !ringRst |=> idle);

endmodule

// File: rtl/tx_desc_walker.sv
module tx_desc_walker
  import txr_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int REG_W   = 16,
  parameter int STAT_W  = 16,
  parameter int LEN_W   = 12,
  parameter int OWN_BIT = 15,
  parameter int LEN_MIN = 60,
  parameter int LEN_MAX = 1514
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ringRst,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [REG_W-1:0]  regWrData,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRdValid,
  input  logic [ADDR_W-1:0] memRdData,
  output logic              memWrReq,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [STAT_W-1:0] memWrData,
  input  logic              memWrAck,
  output logic              frameValid,
  output logic [ADDR_W-1:0] frameAddr,
  output logic [LEN_W-1:0]  frameLen,
  input  logic              frameDone,
  output logic              txDone,
  output logic              txLenErr
);
  walk_strobe_t stb;
  logic idle, pollPending, ownerIn, lenOk;

  txr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ringRst(ringRst), .pollPending(pollPending),
    .memRdValid(memRdValid), .ownerIn(ownerIn), .lenOk(lenOk),
    .frameDone(frameDone), .memWrAck(memWrAck), .memRdReq(memRdReq),
    .memWrReq(memWrReq), .frameValid(frameValid), .idle(idle), .stb(stb)
  );

  txr_datapath #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .STAT_W(STAT_W), .LEN_W(LEN_W),
    .OWN_BIT(OWN_BIT), .LEN_MIN(LEN_MIN), .LEN_MAX(LEN_MAX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .idle(idle), .stb(stb), .memRdData(memRdData),
    .memRdAddr(memRdAddr), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .frameAddr(frameAddr), .frameLen(frameLen), .pollPending(pollPending),
    .ownerIn(ownerIn), .lenOk(lenOk), .txDone(txDone), .txLenErr(txLenErr)
  );

  // R10: a waiting read keeps its request and address
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq && !memRdValid && !ringRst |=> memRdReq && $stable(memRdAddr));

  // R6: an offered frame stays stable until accepted
  p_frame_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameValid && !frameDone && !ringRst |=> frameValid && $stable(frameAddr) && $stable(frameLen));

  // R6: only legal lengths are offered
  p_frame_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |-> frameLen >= LEN_W'(LEN_MIN) && frameLen <= LEN_W'(LEN_MAX));

  // R7: a completion pulse follows an acknowledged write-back
  p_done_after_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> $past(memWrReq && memWrAck));

endmodule

// File: tb/tx_desc_walker_tb.sv
`timescale 1ns/1ps
module tx_desc_walker_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ringRst = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic [15:0] regWrData = 16'd0;
  logic memRdReq, memWrReq, frameValid, txDone, txLenErr;
  logic [31:0] memRdAddr, memWrAddr, frameAddr;
  logic [15:0] memWrData;
  logic [11:0] frameLen;
  logic memRdValid = 1'b0;
  logic [31:0] memRdData = 32'd0;
  logic memWrAck = 1'b0;
  logic frameDone = 1'b0;

  always #2.5 clk = ~clk;

  tx_desc_walker u_dut (
    .clk(clk), .rstN(rstN), .ringRst(ringRst), .regWrEn(regWrEn),
    .regSel(regSel), .regWrData(regWrData), .memRdReq(memRdReq),
    .memRdAddr(memRdAddr), .memRdValid(memRdValid), .memRdData(memRdData),
    .memWrReq(memWrReq), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .memWrAck(memWrAck), .frameValid(frameValid), .frameAddr(frameAddr),
    .frameLen(frameLen), .frameDone(frameDone), .txDone(txDone),
    .txLenErr(txLenErr)
  );

  logic [31:0] mem [0:63];
  logic [43:0] expQ[$];
  int nCmp = 0, nBad = 0;
  int rdLat = 1, frLat = 2;
  int rdCount = 0, wrCount = 0, doneCnt = 0, errCnt = 0, frameCnt = 0;
  logic [31:0] lastRdAddr = 32'd0;
  logic spurReq = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setDesc(input logic [31:0] a, input logic [15:0] st, input logic [11:0] len,
                         input logic [3:0] nib, input logic [31:0] buff, input logic [31:0] nx);
    mem[a[7:2]]      = {nib, len, st};
    mem[a[7:2] + 1]  = buff;
    mem[a[7:2] + 2]  = nx;
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic expectFrame(input logic [31:0] buff, input logic [11:0] len);
    expQ.push_back({buff, len});
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // memory read responder with programmable latency
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (memRdValid) begin
        memRdValid = 1'b0; cnt = 0;
      end else if (spurReq) begin
        memRdValid = 1'b1; memRdData = 32'hFFFF_FFFF; spurReq = 1'b0;
      end else if (memRdReq) begin
        if (cnt >= rdLat) begin
          memRdValid = 1'b1; memRdData = mem[memRdAddr[7:2]];
          rdCount++; lastRdAddr = memRdAddr; cnt = 0;
        end else cnt++;
      end
    end
  end

  // status write sink
  initial begin
    forever begin
      @(negedge clk);
      if (memWrAck) memWrAck = 1'b0;
      else if (memWrReq) begin
        mem[memWrAddr[7:2]][15:0] = memWrData;
        memWrAck = 1'b1; wrCount++;
      end
    end
  end

  // frame sink and scoreboard monitor
  initial begin
    bit inFrame;
    int w;
    logic [43:0] e;
    inFrame = 0; w = 0;
    forever begin
      @(negedge clk);
      if (txDone) doneCnt++;
      if (txLenErr) errCnt++;
      if (frameDone) frameDone = 1'b0;
      else if (frameValid) begin
        if (!inFrame) begin
          inFrame = 1; w = 0; frameCnt++;
          if (expQ.size() == 0) chk(0, "R6 unexpected frame", {frameAddr[19:0], frameLen}, 32'd0);
          else begin
            e = expQ.pop_front();
            chk({frameAddr, frameLen} == e, "R6 frame addr/len", {frameAddr[19:0], frameLen}, e[31:0]);
          end
        end
        if (w >= frLat) begin
          frameDone = 1'b1; inFrame = 0;
        end else w++;
      end else inFrame = 0;
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    int r0, d0, e0, f0, w0;
    for (int i = 0; i < 64; i++) mem[i] = 32'd0;
    cyc(3);
    chk(!memRdReq && !memWrReq && !frameValid && !txDone && !txLenErr, "R1 outputs in reset",
        {memRdReq, memWrReq, frameValid, txDone, txLenErr}, 32'd0);
    chk(memWrAddr == 32'd0, "R1 position after reset", memWrAddr, 32'd0);
    rstN = 1'b1;
    cyc(2);
    chk(!memRdReq && !memWrReq && !frameValid, "R1 outputs after reset",
        {memRdReq, memWrReq, frameValid}, 32'd0);

    // three-entry ring closed by its last link (R9)
    setDesc(32'h40, 16'h8123, 12'd100, 4'hF, 32'h0000_1000, 32'h60);
    setDesc(32'h60, 16'h8045, 12'd1514, 4'h0, 32'h0000_2000, 32'h80);
    setDesc(32'h80, 16'h8006, 12'd60, 4'h0, 32'h0000_3000, 32'h40);
    regWrite(2'd0, 16'h0040);
    regWrite(2'd1, 16'h0000);
    chk(memWrAddr == 32'h40, "R2 base load moves position", memWrAddr, 32'h40);

    // R3: poll value other than 1 ignored
    r0 = rdCount;
    regWrite(2'd2, 16'h0002);
    cyc(20);
    chk(rdCount == r0 && !memRdReq, "R3 non-1 poll ignored", rdCount - r0, 0);

    // main walk, latency 1
    expectFrame(32'h1000, 12'd100);
    expectFrame(32'h2000, 12'd1514);
    expectFrame(32'h3000, 12'd60);
    r0 = rdCount; d0 = doneCnt;
    regWrite(2'd2, 16'h0001);
    cyc(300);
    chk(doneCnt - d0 == 3, "R7 completion pulses", doneCnt - d0, 3);
    chk(rdCount - r0 == 10, "R4 R5 R9 word reads for wrapped walk", rdCount - r0, 10);
    chk(mem[16][15:0] == 16'h0123, "R7 status write-back A", mem[16][15:0], 16'h0123);
    chk(mem[24][15:0] == 16'h0045, "R7 status write-back B", mem[24][15:0], 16'h0045);
    chk(mem[32][15:0] == 16'h0006, "R7 status write-back C", mem[32][15:0], 16'h0006);
    chk(lastRdAddr == 32'h40, "R9 stopped after wrap to first", lastRdAddr, 32'h40);
    chk(expQ.size() == 0, "R6 all frames offered", expQ.size(), 0);

    // length window edges, latency 3
    rdLat = 3;
    setDesc(32'h40, 16'h8011, 12'd59, 4'h0, 32'h0000_1100, 32'h60);
    setDesc(32'h60, 16'h8022, 12'd1515, 4'h0, 32'h0000_2200, 32'h80);
    setDesc(32'h80, 16'h8033, 12'd60, 4'h0, 32'h0000_3300, 32'h40);
    expectFrame(32'h3300, 12'd60);
    r0 = rdCount; d0 = doneCnt; e0 = errCnt; f0 = frameCnt;
    regWrite(2'd2, 16'h0001);
    cyc(400);
    chk(errCnt - e0 == 2, "R8 length error pulses", errCnt - e0, 2);
    chk(doneCnt - d0 == 1, "R8 only legal length completes", doneCnt - d0, 1);
    chk(frameCnt - f0 == 1, "R8 bad lengths not offered", frameCnt - f0, 1);
    chk(mem[16][15:0] == 16'h0011 && mem[24][15:0] == 16'h0022, "R8 ownership released",
        {mem[16][15:0], mem[24][15:0]}, 32'h0011_0022);
    chk(rdCount - r0 == 10, "R10 reads under latency 3", rdCount - r0, 10);

    // R12: poll during a scan
    rdLat = 0; frLat = 5;
    setDesc(32'h40, 16'h8000, 12'd200, 4'h0, 32'h0000_1200, 32'h60);
    expectFrame(32'h1200, 12'd200);
    r0 = rdCount;
    regWrite(2'd2, 16'h0001);
    cyc(3);
    regWrite(2'd2, 16'h0001);
    cyc(200);
    chk(rdCount - r0 == 5, "R12 remembered poll rescans once", rdCount - r0, 5);
    chk(lastRdAddr == 32'h60, "R12 rescan from stop position", lastRdAddr, 32'h60);

    // R11: ring reset during a frame offer
    frLat = 40;
    setDesc(32'h60, 16'h8077, 12'd300, 4'h0, 32'h0000_2300, 32'h80);
    expectFrame(32'h2300, 12'd300);
    d0 = doneCnt; w0 = wrCount;
    regWrite(2'd2, 16'h0001);
    for (int i = 0; i < 100 && !frameValid; i++) @(negedge clk);
    ringRst = 1'b1;
    @(negedge clk);
    ringRst = 1'b0;
    chk(!frameValid && !memRdReq && !memWrReq, "R11 requests dropped", {frameValid, memRdReq, memWrReq}, 32'd0);
    cyc(60);
    chk(doneCnt == d0 && wrCount == w0, "R11 abandoned descriptor not completed", wrCount - w0, 0);
    chk(mem[24][15:0] == 16'h8077, "R11 status left owned", mem[24][15:0], 16'h8077);
    r0 = rdCount;
    regWrite(2'd2, 16'h0001);
    cyc(40);
    chk(lastRdAddr == 32'h40 && rdCount - r0 == 1, "R11 position back at base", lastRdAddr, 32'h40);

    // R10: stray valid without request
    w0 = wrCount; f0 = frameCnt;
    @(negedge clk); spurReq = 1'b1;
    cyc(20);
    chk(!memRdReq && wrCount == w0 && frameCnt == f0, "R10 stray valid ignored", {memRdReq, memWrReq}, 32'd0);

    // R2: base rewrites while idle
    regWrite(2'd0, 16'h0080);
    regWrite(2'd2, 16'h0001);
    cyc(40);
    chk(lastRdAddr == 32'h80, "R2 low half sets position", lastRdAddr, 32'h80);
    regWrite(2'd1, 16'h0001);
    regWrite(2'd2, 16'h0001);
    cyc(40);
    chk(lastRdAddr == 32'h0001_0080, "R2 high half sets position", lastRdAddr, 32'h0001_0080);
    chk(expQ.size() == 0, "R6 scoreboard drained", expQ.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule